// File: doc/BRIEF.md
# DMA Channel Register Block

This block is the register face of one channel of a descriptor-driven DMA engine. It decodes a 256-byte, word-addressed register window that holds a control/status word, the address of the descriptor now loaded, the six descriptor words (transfer info, source, destination, length, 2D stride and next-descriptor address) and an error register. It keeps the channel's run state and hands a small sequencer interface the run and abort controls. The sequencer reports in return when a descriptor finishes, when the engine has really stopped, when it sees an error, and the peripheral request and wait conditions.

Software starts the channel by setting the run bit. It pauses the channel by clearing that bit and then polling the paused flag until the engine reports it has stopped. One write that carries abort, both completion flags and run together drops the current descriptor, acknowledges the completion and resumes the chain. The completion and error flags are write-one-to-clear, so acknowledging them cannot disturb other state. A write with the reset bit set clears every register of the channel.

Top module: `dma_chan_regs`

## Requirements
- R1: After rst_n is released every register of the window reads 0, and seq_run, seq_abort and irq are 0.
- R2: Word offsets 0x04 (descriptor address), 0x08 (info), 0x0C (source), 0x10 (destination), 0x14 (length), 0x18 (stride) and 0x1C (next address) read back the last value written. Unaligned addresses and word offsets above 0x20 read 0.
- R3: A write to control/status (offset 0x00) with bit 0 (run) set raises seq_run and the run bit one cycle later.
- R4: A control/status write with bit 0 clear drops seq_run one cycle later. Paused (bit 4) reads 1 only while run is 0, seq_halted is 1 and the descriptor address is nonzero.
- R5: End (bit 1) and interrupt (bit 2) clear only when a control/status write carries a 1 in their position. A 0 there leaves them set.
- R6: A seq_done pulse sets end, sets interrupt only if info bit 0 is 1, and copies the next-address word into the descriptor address. If the next-address word is 0, run clears.
- R7: irq is 1 exactly when the interrupt flag or the error flag (control/status bit 8) is set.
- R8: A control/status write with bit 30 (abort) set gives a one-cycle pulse on seq_abort, and bit 30 reads 0. Writing bits 30, 2, 1 and 0 together clears end and interrupt and leaves the channel running.
- R9: A seq_err pulse sets the matching bits of the error register (offset 0x20, bits 2:0), and a write of 1 to a bit there clears it. Error (bit 8) is the OR of those bits. While it is set, run is forced to 0.
- R10: A control/status write with bit 31 set clears every register of the window within one cycle. seq_run and irq then read 0, and bit 31 always reads 0.
- R11: Control/status bits 28 and 29 are plain storage bits that read back as written.
- R12: Control/status bit 3 follows seq_dreq and bit 6 follows seq_wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte offset within the channel window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| seq_done | input | 1 | Sequencer finished the current descriptor |
| seq_halted | input | 1 | Sequencer has actually stopped moving data |
| seq_err | input | 3 | Error event pulses, one per error class |
| seq_dreq | input | 1 | Peripheral request level |
| seq_wait | input | 1 | Sequencer waiting on outstanding writes |
| seq_run | output | 1 | Channel is allowed to run |
| seq_abort | output | 1 | One-cycle request to drop the current descriptor |
| irq | output | 1 | Channel interrupt |

## Verification
The paused flag is checked both before and after seq_halted rises. A design that reports pause as soon as run clears would show 1 too early and would let software tear down a transfer that is still moving. The completion flags are written with 0 as well as with 1, which catches a design that stores them like plain bits and loses an unacknowledged completion. A descriptor is finished with the interrupt enable set and then again with a zero next address, so a missing enable test or a missing chain-end stop shows up in the status word and in the descriptor address. The error path is checked with a set-then-restart attempt, with partial clears of the error register, and with a reset that comes while the channel is running and its descriptor words are loaded. Each of these exposes any flag or descriptor word that a wrong design would keep.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
   // word indices inside the channel window (byte offset / 4)
   localparam int unsigned W_CS     = 0;
   localparam int unsigned W_CBA    = 1;
   localparam int unsigned W_INFO   = 2;
   localparam int unsigned W_SRC    = 3;
   localparam int unsigned W_DST    = 4;
   localparam int unsigned W_LEN    = 5;
   localparam int unsigned W_STRIDE = 6;
   localparam int unsigned W_NEXT   = 7;
   localparam int unsigned W_DEBUG  = 8;
   localparam int unsigned NUM_WORDS = 9;
   // descriptor words occupy W_CBA..W_NEXT
   localparam int unsigned NUM_DESC  = W_NEXT - W_CBA + 1;

   // control/status bit positions
   localparam int unsigned B_RUN    = 0;
   localparam int unsigned B_END    = 1;
   localparam int unsigned B_INT    = 2;
   localparam int unsigned B_DREQ   = 3;
   localparam int unsigned B_PAUSED = 4;
   localparam int unsigned B_WAIT   = 6;
   localparam int unsigned B_ERR    = 8;
   localparam int unsigned B_WFW    = 28;
   localparam int unsigned B_NODBG  = 29;
   localparam int unsigned B_ABORT  = 30;
   localparam int unsigned B_RESET  = 31;

   // info word bit that enables the completion interrupt
   localparam int unsigned B_INTEN  = 0;

   typedef struct packed {
      logic run;
      logic done_f;
      logic int_f;
      logic wfw;
      logic nodbg;
   } cs_state_t;
endpackage

// File: rtl/dma_chan_decode.sv
module dma_chan_decode #(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned NUM_WORDS = 9,
   localparam int unsigned IDX_W    = ADDR_W - 2
) (
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   output logic [NUM_WORDS-1:0] wr_sel,
   output logic [IDX_W-1:0]     rd_idx,
   output logic                 rd_hit
);
   if (ADDR_W < 6) begin : g_bad_addr
      $error("dma_chan_decode: ADDR_W too small for the register window");
   end

   assign rd_idx = bus_addr[ADDR_W-1:2];
   assign rd_hit = (bus_addr[1:0] == 2'b00) && (32'(rd_idx) < NUM_WORDS);

   for (genvar g = 0; g < NUM_WORDS; g++) begin : g_sel
      assign wr_sel[g] = bus_wr && rd_hit && (32'(rd_idx) == g);
   end
endmodule

// File: rtl/dma_chan_desc.sv
module dma_chan_desc #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_DESC = 7
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             soft_clr,
   input  logic [NUM_DESC-1:0]              wr_sel,
   input  logic [DATA_W-1:0]                wdata,
   input  logic                             advance,
   output logic [NUM_DESC-1:0][DATA_W-1:0]  desc_q
);
   localparam int unsigned LAST = NUM_DESC - 1;

   if (NUM_DESC < 2) begin : g_bad_desc
      $error("dma_chan_desc: need at least address and next words");
   end

   for (genvar g = 0; g < NUM_DESC; g++) begin : g_word
      if (g == 0) begin : g_addr
         // loaded-descriptor address: follows the chain on completion
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          desc_q[g] <= '0;
            else if (soft_clr)   desc_q[g] <= '0;
            else if (wr_sel[g])  desc_q[g] <= wdata;
            else if (advance)    desc_q[g] <= desc_q[LAST];
         end
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          desc_q[g] <= '0;
            else if (soft_clr)   desc_q[g] <= '0;
            else if (wr_sel[g])  desc_q[g] <= wdata;
         end
      end
   end
endmodule

// File: rtl/dma_chan_err.sv
module dma_chan_err #(
   parameter int unsigned ERR_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_clr,
   input  logic             wr,
   input  logic [ERR_W-1:0] w1c,
   input  logic [ERR_W-1:0] set,
   output logic [ERR_W-1:0] err_q,
   output logic             err_any
);
   if (ERR_W < 1 || ERR_W > 8) begin : g_bad_err
      $error("dma_chan_err: ERR_W out of range");
   end

   for (genvar g = 0; g < ERR_W; g++) begin : g_bit
      // a new event wins over a clear in the same cycle
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            err_q[g] <= 1'b0;
         else if (soft_clr)     err_q[g] <= 1'b0;
         else if (set[g])       err_q[g] <= 1'b1;
         else if (wr && w1c[g]) err_q[g] <= 1'b0;
      end
   end

   assign err_any = |err_q;
endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
   import dma_chan_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      soft_clr,
   input  logic      cs_wr,
   input  logic      w_run,
   input  logic      w_end,
   input  logic      w_int,
   input  logic      w_wfw,
   input  logic      w_nodbg,
   input  logic      w_abort,
   input  logic      seq_done,
   input  logic      chain_end,
   input  logic      int_en,
   input  logic      err_new,
   input  logic      err_held,
   output cs_state_t st_q,
   output logic      abort_q
);
   cs_state_t st_d;

   always_comb begin
      st_d = st_q;
      if (cs_wr) begin
         st_d.run   = w_run;
         st_d.wfw   = w_wfw;
         st_d.nodbg = w_nodbg;
         if (w_end) st_d.done_f = 1'b0;
         if (w_int) st_d.int_f  = 1'b0;
      end
      if (seq_done) begin
         st_d.done_f = 1'b1;
         if (int_en)    st_d.int_f = 1'b1;
         if (chain_end) st_d.run   = 1'b0;
      end
      if (err_new || err_held) st_d.run = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= '0;
         abort_q <= 1'b0;
      end else if (soft_clr) begin
         st_q    <= '0;
         abort_q <= 1'b0;
      end else begin
         st_q    <= st_d;
         abort_q <= cs_wr && w_abort;
      end
   end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
   import dma_chan_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned ERR_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              seq_done,
   input  logic              seq_halted,
   input  logic [ERR_W-1:0]  seq_err,
   input  logic              seq_dreq,
   input  logic              seq_wait,
   output logic              seq_run,
   output logic              seq_abort,
   output logic              irq
);
   localparam int unsigned IDX_W = ADDR_W - 2;

   if (DATA_W != 32) begin : g_bad_data
      $error("dma_chan_regs: control/status layout needs DATA_W of 32");
   end

   logic [NUM_WORDS-1:0]            wr_sel;
   logic [IDX_W-1:0]                rd_idx;
   logic                            rd_hit;
   logic [NUM_DESC-1:0][DATA_W-1:0] desc_q;
   logic [ERR_W-1:0]                err_q;
   logic                            err_any;
   cs_state_t                       st_q;
   logic                            abort_q;
   logic                            soft_clr;
   logic                            chain_end;
   logic                            paused;
   logic [DATA_W-1:0]               cs_rd;

   dma_chan_decode #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) u_dec (
      .bus_wr (bus_wr),
      .bus_addr (bus_addr),
      .wr_sel (wr_sel),
      .rd_idx (rd_idx),
      .rd_hit (rd_hit)
   );

   assign soft_clr  = wr_sel[W_CS] && bus_wdata[B_RESET];
   assign chain_end = (desc_q[W_NEXT-W_CBA] == '0);

   dma_chan_desc #(.DATA_W(DATA_W), .NUM_DESC(NUM_DESC)) u_desc (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_clr (soft_clr),
      .wr_sel   (wr_sel[W_NEXT:W_CBA]),
      .wdata    (bus_wdata),
      .advance  (seq_done),
      .desc_q   (desc_q)
   );

   dma_chan_err #(.ERR_W(ERR_W)) u_err (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_clr (soft_clr),
      .wr       (wr_sel[W_DEBUG]),
      .w1c      (bus_wdata[ERR_W-1:0]),
      .set      (seq_err),
      .err_q    (err_q),
      .err_any  (err_any)
   );

   dma_chan_ctl u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .soft_clr  (soft_clr),
      .cs_wr     (wr_sel[W_CS]),
      .w_run     (bus_wdata[B_RUN]),
      .w_end     (bus_wdata[B_END]),
      .w_int     (bus_wdata[B_INT]),
      .w_wfw     (bus_wdata[B_WFW]),
      .w_nodbg   (bus_wdata[B_NODBG]),
      .w_abort   (bus_wdata[B_ABORT]),
      .seq_done  (seq_done),
      .chain_end (chain_end),
      .int_en    (desc_q[W_INFO-W_CBA][B_INTEN]),
      .err_new   (|seq_err),
      .err_held  (err_any),
      .st_q      (st_q),
      .abort_q   (abort_q)
   );

   // paused only once the engine confirms it has stopped
   assign paused = !st_q.run && seq_halted && (desc_q[0] != '0);

   always_comb begin
      cs_rd           = '0;
      cs_rd[B_RUN]    = st_q.run;
      cs_rd[B_END]    = st_q.done_f;
      cs_rd[B_INT]    = st_q.int_f;
      cs_rd[B_DREQ]   = seq_dreq;
      cs_rd[B_PAUSED] = paused;
      cs_rd[B_WAIT]   = seq_wait;
      cs_rd[B_ERR]    = err_any;
      cs_rd[B_WFW]    = st_q.wfw;
      cs_rd[B_NODBG]  = st_q.nodbg;
   end

   always_comb begin
      bus_rdata = '0;
      if (rd_hit) begin
         if (32'(rd_idx) == W_CS)
            bus_rdata = cs_rd;
         else if (32'(rd_idx) == W_DEBUG)
            bus_rdata = DATA_W'(err_q);
         else
            bus_rdata = desc_q[32'(rd_idx) - W_CBA];
      end
   end

   assign seq_run   = st_q.run;
   assign seq_abort = abort_q;
   assign irq       = st_q.int_f || err_any;
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned ERR_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              wd_run,
   input logic              wd_abort,
   input logic              wd_reset,
   input logic              seq_done,
   input logic [ERR_W-1:0]  seq_err,
   input logic              err_held,
   input logic              seq_run,
   input logic              seq_abort,
   input logic              irq
);
   logic cs_wr;
   assign cs_wr = bus_wr && (bus_addr == '0);

   // R3
   a_r3_run_starts: assert property (@(posedge clk) disable iff (!rst_n)
      cs_wr && wd_run && !wd_reset && !seq_done && (seq_err == '0) && !err_held
      |=> seq_run);

   // R4
   a_r4_pause_drops_run: assert property (@(posedge clk) disable iff (!rst_n)
      cs_wr && !wd_run |=> !seq_run);

   // R7
   a_r7_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(seq_done) || $past(|seq_err));

   // R8
   a_r8_abort_from_write: assert property (@(posedge clk) disable iff (!rst_n)
      seq_abort |-> $past(cs_wr && wd_abort && !wd_reset));

   // R9
   a_r9_error_stops: assert property (@(posedge clk) disable iff (!rst_n)
      (|seq_err) |=> !seq_run);

   // R10
   a_r10_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
      cs_wr && wd_reset |=> !seq_run && !irq && !seq_abort);
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.ADDR_W(ADDR_W), .ERR_W(ERR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .wd_run    (bus_wdata[0]),
   .wd_abort  (bus_wdata[30]),
   .wd_reset  (bus_wdata[31]),
   .seq_done  (seq_done),
   .seq_err   (seq_err),
   .err_held  (err_any),
   .seq_run   (seq_run),
   .seq_abort (seq_abort),
   .irq       (irq)
);

// File: tb/dma_chan_regs_bench.sv
module dma_chan_regs_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        seq_done = 1'b0;
   logic        seq_halted = 1'b0;
   logic [2:0]  seq_err = '0;
   logic        seq_dreq = 1'b0;
   logic        seq_wait = 1'b0;
   logic        seq_run, seq_abort, irq;

   int n_checks = 0;
   int n_fail = 0;
   logic [31:0] model [1:7];

   always #5 clk = ~clk;

   dma_chan_regs u_dma_chan_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .seq_done(seq_done),
      .seq_halted(seq_halted), .seq_err(seq_err), .seq_dreq(seq_dreq),
      .seq_wait(seq_wait), .seq_run(seq_run), .seq_abort(seq_abort), .irq(irq)
   );

   // expected control/status word from the requirement bit positions
   function automatic logic [31:0] cs_exp(input logic run, input logic en,
         input logic it, input logic pause, input logic er, input logic [1:0] hi);
      logic [31:0] v;
      v = '0;
      v[0] = run; v[1] = en; v[2] = it; v[3] = seq_dreq; v[4] = pause;
      v[6] = seq_wait; v[8] = er; v[29:28] = hi;
      return v;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
      bus_addr = a;
      #1;
      check(req, bus_rdata, exp);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic done_pulse();
      @(negedge clk);
      seq_done = 1'b1;
      @(negedge clk);
      seq_done = 1'b0;
   endtask

   task automatic err_pulse(input logic [2:0] e);
      @(negedge clk);
      seq_err = e;
      @(negedge clk);
      seq_err = '0;
   endtask

   initial begin : watchdog
      #1_000_000;
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: everything clear after reset
      for (int i = 0; i < 9; i++) rd("R1", 8'(i * 4), 32'h0);
      check("R1 run", {31'b0, seq_run}, 32'h0);
      check("R1 irq", {31'b0, irq}, 32'h0);
      check("R1 abort", {31'b0, seq_abort}, 32'h0);
      for (int i = 1; i < 8; i++) model[i] = '0;

      // R2: random descriptor traffic read back
      for (int k = 0; k < 30; k++) begin
         int idx;
         logic [31:0] v;
         idx = $urandom_range(7, 1);
         v = $urandom;
         wr(8'(idx * 4), v);
         model[idx] = v;
         idx = $urandom_range(7, 1);
         rd("R2", 8'(idx * 4), model[idx]);
      end
      rd("R2 unmapped", 8'h24, 32'h0);
      rd("R2 unmapped", 8'h80, 32'h0);
      rd("R2 unaligned", 8'h06, 32'h0);

      // R3: start
      wr(8'h04, 32'h1000);
      wr(8'h08, 32'h1);
      wr(8'h1C, 32'h2000);
      wr(8'h00, 32'h1);
      check("R3 run", {31'b0, seq_run}, 32'h1);
      rd("R3", 8'h00, cs_exp(1, 0, 0, 0, 0, 0));

      // R4: pause handshake
      wr(8'h00, 32'h0);
      check("R4 run", {31'b0, seq_run}, 32'h0);
      rd("R4 not yet", 8'h00, cs_exp(0, 0, 0, 0, 0, 0));
      seq_halted = 1'b1;
      rd("R4 paused", 8'h00, cs_exp(0, 0, 0, 1, 0, 0));
      seq_halted = 1'b0;

      // R6: completion with a following descriptor
      wr(8'h00, 32'h1);
      done_pulse();
      rd("R6 cs", 8'h00, cs_exp(1, 1, 1, 0, 0, 0));
      rd("R6 advance", 8'h04, 32'h2000);
      check("R7 irq int", {31'b0, irq}, 32'h1);
      // R6: chain end stops the channel
      wr(8'h1C, 32'h0);
      done_pulse();
      rd("R6 chain end", 8'h00, cs_exp(0, 1, 1, 0, 0, 0));
      rd("R6 addr", 8'h04, 32'h0);
      check("R6 run", {31'b0, seq_run}, 32'h0);

      // R5: write-one-to-clear
      wr(8'h00, 32'h0);
      rd("R5 zero keeps", 8'h00, cs_exp(0, 1, 1, 0, 0, 0));
      wr(8'h00, 32'h6);
      rd("R5 cleared", 8'h00, cs_exp(0, 0, 0, 0, 0, 0));
      check("R7 irq low", {31'b0, irq}, 32'h0);
      // R6: interrupt enable off sets end only
      wr(8'h08, 32'h0);
      done_pulse();
      rd("R6 no inten", 8'h00, cs_exp(0, 1, 0, 0, 0, 0));
      check("R7 irq off", {31'b0, irq}, 32'h0);
      wr(8'h00, 32'h2);
      wr(8'h08, 32'h1);

      // R8: abort after a pause
      wr(8'h04, 32'h3000);
      wr(8'h1C, 32'h4000);
      wr(8'h00, 32'h1);
      done_pulse();
      wr(8'h00, 32'h0);
      seq_halted = 1'b1;
      rd("R8 paused", 8'h00, cs_exp(0, 1, 1, 1, 0, 0));
      wr(8'h00, 32'h4000_0007);
      check("R8 pulse", {31'b0, seq_abort}, 32'h1);
      rd("R8 cs", 8'h00, cs_exp(1, 0, 0, 0, 0, 0));
      check("R8 irq", {31'b0, irq}, 32'h0);
      @(negedge clk);
      check("R8 pulse ends", {31'b0, seq_abort}, 32'h0);
      seq_halted = 1'b0;

      // R9: error capture and stop
      err_pulse(3'b010);
      rd("R9 cs", 8'h00, cs_exp(0, 0, 0, 0, 1, 0));
      rd("R9 debug", 8'h20, 32'h2);
      check("R9 run", {31'b0, seq_run}, 32'h0);
      check("R7 irq err", {31'b0, irq}, 32'h1);
      wr(8'h00, 32'h1);
      rd("R9 held", 8'h00, cs_exp(0, 0, 0, 0, 1, 0));
      wr(8'h20, 32'h2);
      rd("R9 clear", 8'h20, 32'h0);
      rd("R9 cs clear", 8'h00, cs_exp(0, 0, 0, 0, 0, 0));
      err_pulse(3'b101);
      wr(8'h20, 32'h1);
      rd("R9 partial", 8'h20, 32'h4);
      rd("R9 or", 8'h00, cs_exp(0, 0, 0, 0, 1, 0));
      wr(8'h20, 32'h4);
      rd("R9 none", 8'h20, 32'h0);

      // R11: storage bits
      wr(8'h00, 32'h3000_0000);
      rd("R11", 8'h00, cs_exp(0, 0, 0, 0, 0, 2'b11));
      wr(8'h00, 32'h1000_0000);
      rd("R11 one", 8'h00, cs_exp(0, 0, 0, 0, 0, 2'b01));

      // R12: mirrored levels
      seq_dreq = 1'b1;
      rd("R12 dreq", 8'h00, cs_exp(0, 0, 0, 0, 0, 2'b01));
      seq_wait = 1'b1;
      rd("R12 wait", 8'h00, cs_exp(0, 0, 0, 0, 0, 2'b01));
      seq_dreq = 1'b0; seq_wait = 1'b0;

      // R10: soft reset while running and loaded
      wr(8'h08, 32'h1);
      wr(8'h0C, 32'hA5A5_0000);
      wr(8'h00, 32'h3000_0001);
      done_pulse();
      err_pulse(3'b001);
      wr(8'h00, 32'h8000_0000);
      for (int i = 0; i < 9; i++) rd("R10", 8'(i * 4), 32'h0);
      check("R10 run", {31'b0, seq_run}, 32'h0);
      check("R10 irq", {31'b0, irq}, 32'h0);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule